// File: doc/BRIEF.md
# Serial Clock Reset Pattern Detector

This block watches the serial clock line of a slave serial port from the system oscillator domain and recognises a reserved pulse pattern that asks for a chip reset. The pattern is three active-phase pulses of increasing length, each measured in oscillator cycles and checked against its own open window, with short idle gaps between them. When the falling edge that ends the third pulse is seen, the block emits a one-cycle reset strobe for downstream reset logic.

The raw line is XORed with the polarity input and then passed through a two-flop synchronizer. All widths are counted on the synchronized level. A pulse that fails its window abandons the partial pattern. If that pulse fits the first window, it becomes the start of a new attempt.

Top module: `sclk_reset_detect`

## Requirements
- R1: `reset_o` is low while `rst_ni` is low and after reset until a full pattern is seen.
- R2: The first pulse is accepted only when its width W in oscillator cycles satisfies 300 < W < 500. Widths of 300 and 500 are rejected.
- R3: The second pulse is accepted only when 550 < W < 750.
- R4: The third pulse is accepted only when 1050 < W < 1250.
- R5: Each idle gap between accepted pulses must last at least 5 cycles. A shorter gap abandons the pattern.
- R6: When the raw line drops to end a valid third pulse and that low level is first sampled at clock edge k, `reset_o` is high for exactly one cycle, starting at edge k+2.
- R7: A pulse that misses its window returns the detector to idle. If that pulse lies in the first window, it counts as a new first pulse.
- R8: When `pol_i` is 1, the line is inverted before detection. The active phase is then low, and the idle level is high.
- R9: Width counters saturate at 1250, so an overlong pulse can never wrap into a window.
- R10: A raw pulse held for N sampled cycles measures as width N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Raw serial clock line |
| pol_i | input | 1 | Line polarity: 1 inverts the line before detection |
| reset_o | output | 1 | One-cycle chip reset request |

## Verification
The bench probes each window at its exact edges (300, 301, 499, 500, 750, 1050, 1250), because an off-by-one comparison would accept a rejected width or reject a legal one. It drives 4-cycle and 5-cycle gaps. A design that ignores gap length would fire on a bounced clock, and one that is too strict would miss a legal pattern. It replays patterns with a repeated or out-of-order first pulse, which a detector without the restart rule would lose. It sends a 2448-cycle pulse, which a wrapping counter would take for a 400-cycle first pulse. It also runs the full pattern with inverted polarity.

// File: rtl/sclk_rst_pkg.sv
package sclk_rst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2
  } det_state_e;
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sclk_width_meter.sv
module sclk_width_meter #(
  parameter int SAT   = 1250,
  parameter int CNT_W = $clog2(SAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic [CNT_W-1:0] hi_w_o,
  output logic [CNT_W-1:0] lo_w_o
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

  logic             lvl_q;
  logic [CNT_W-1:0] hi_cnt, lo_cnt;

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
  assign hi_w_o = hi_cnt;
  assign lo_w_o = lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (rise_o)                         hi_cnt <= CNT_W'(1);
      else if (lvl_i && hi_cnt != SAT_V)  hi_cnt <= hi_cnt + 1'b1;
      if (fall_o)                         lo_cnt <= CNT_W'(1);
      else if (!lvl_i && lo_cnt != SAT_V) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  a_r9_hi_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt <= SAT_V);
  a_r9_hold_at_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cnt == SAT_V && lvl_i && lvl_q) |=> (hi_cnt == SAT_V));
endmodule

// File: rtl/sclk_reset_detect.sv
module sclk_reset_detect
  import sclk_rst_pkg::*;
#(
  parameter int W1_MIN  = 300,
  parameter int W1_MAX  = 500,
  parameter int W2_MIN  = 550,
  parameter int W2_MAX  = 750,
  parameter int W3_MIN  = 1050,
  parameter int W3_MAX  = 1250,
  parameter int GAP_MIN = 5,
  parameter int SYNC_N  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic pol_i,
  output logic reset_o
);
  localparam int CNT_W = $clog2(W3_MAX + 1);

  logic             lvl, rise, fall;
  logic [CNT_W-1:0] hi_w, lo_w;
  det_state_e       state_q, state_d;
  logic             rst_d;

  sclk_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sclk_i ^ pol_i),
    .q_o   (lvl)
  );

  sclk_width_meter #(.SAT(W3_MAX), .CNT_W(CNT_W)) u_meter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .rise_o(rise),
    .fall_o(fall),
    .hi_w_o(hi_w),
    .lo_w_o(lo_w)
  );

  function automatic logic in_win(logic [CNT_W-1:0] w, int lo, int hi);
    return (w > CNT_W'(lo)) && (w < CNT_W'(hi));
  endfunction

  logic win1, win2, win3, gap_ok;
  assign win1   = in_win(hi_w, W1_MIN, W1_MAX);
  assign win2   = in_win(hi_w, W2_MIN, W2_MAX);
  assign win3   = in_win(hi_w, W3_MIN, W3_MAX);
  assign gap_ok = lo_w >= CNT_W'(GAP_MIN);

  always_comb begin
    state_d = state_q;
    rst_d   = 1'b0;
    if (rise && !gap_ok) begin
      state_d = ST_IDLE;
    end else if (fall) begin
      unique case (state_q)
        ST_ONE:  state_d = win2 ? ST_TWO : (win1 ? ST_ONE : ST_IDLE);
        ST_TWO: begin
          rst_d   = win3;
          state_d = (!win3 && win1) ? ST_ONE : ST_IDLE;
        end
        default: state_d = win1 ? ST_ONE : ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      reset_o <= 1'b0;
    end else begin
      state_q <= state_d;
      reset_o <= rst_d;
    end
  end

  a_r6_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |=> !reset_o);
  a_r6_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> $past(fall));
  a_r4_from_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> $past(state_q == ST_TWO));
  a_r5_short_gap_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && lo_w < CNT_W'(GAP_MIN)) |=> (state_q == ST_IDLE));
  a_r1_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> !reset_o);
endmodule

// File: tb/sclk_reset_detect_bench.sv
module sclk_reset_detect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic pol = 1'b0;
  logic rst_req;

  int n_tests = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sclk_reset_detect u_sclk_reset_detect (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sclk_i (sclk),
    .pol_i  (pol),
    .reset_o(rst_req)
  );

  // reference model: behavioural, integer based
  int hist[$] = '{0, 0};
  int m_lvq = 0, m_hi = 0, m_lo = 0, m_st = 0;
  bit m_exp = 1'b0;

  function automatic bit win(int w, int lo, int hi);
    return (w > lo) && (w < hi);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0};
      m_lvq = 0; m_hi = 0; m_lo = 0; m_st = 0; m_exp = 1'b0;
    end else begin
      int lv;
      bit rise, fall, nx;
      lv = hist[0];
      rise = (lv == 1) && (m_lvq == 0);
      fall = (lv == 0) && (m_lvq == 1);
      nx = 1'b0;
      if (rise && m_lo < 5) m_st = 0;
      else if (fall) begin
        if (m_st == 2 && win(m_hi, 1050, 1250)) begin nx = 1'b1; m_st = 0; end
        else if (m_st == 1 && win(m_hi, 550, 750)) m_st = 2;
        else if (win(m_hi, 300, 500)) m_st = 1;
        else m_st = 0;
      end
      if (rise) m_hi = 1;
      else if (lv == 1 && m_hi < 1250) m_hi++;
      if (fall) m_lo = 1;
      else if (lv == 0 && m_lo < 1250) m_lo++;
      m_lvq = lv;
      m_exp = nx;
      void'(hist.pop_front());
      hist.push_back(int'(sclk ^ pol));
    end
  end

  // R6 R10: per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (rst_req !== m_exp) begin
        n_fail++;
        $display("FAIL R6 cycle compare t=%0t actual=%0b expected=%0b", $time, rst_req, m_exp);
      end
      if (rst_req === 1'b1) pulses++;
    end
  end

  task automatic drive(bit act, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sclk = act ^ pol;
    end
  endtask

  task automatic pattern(int w1, int w2, int w3, int gap);
    drive(1, w1); drive(0, gap);
    drive(1, w2); drive(0, gap);
    drive(1, w3); drive(0, 40);
  endtask

  task automatic expect_pulses(int exp, string req);
    n_tests++;
    if (pulses != exp) begin
      n_fail++;
      $display("FAIL %s pulse count actual=%0d expected=%0d", req, pulses, exp);
    end
    pulses = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    n_tests++;
    if (rst_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 during reset actual=%0b expected=0", rst_req);
    end
    rst_n = 1'b1;
    drive(0, 20);
    expect_pulses(0, "R1");
    pattern(400, 650, 1150, 10);  expect_pulses(1, "R2");
    pattern(300, 650, 1150, 10);  expect_pulses(0, "R2");
    pattern(500, 650, 1150, 10);  expect_pulses(0, "R2");
    pattern(301, 551, 1051, 10);  expect_pulses(1, "R3");
    pattern(499, 749, 1249, 10);  expect_pulses(1, "R4");
    pattern(400, 750, 1150, 10);  expect_pulses(0, "R3");
    pattern(400, 650, 1250, 10);  expect_pulses(0, "R4");
    pattern(400, 650, 1050, 10);  expect_pulses(0, "R4");
    pattern(400, 650, 1150, 4);   expect_pulses(0, "R5");
    pattern(400, 650, 1150, 5);   expect_pulses(1, "R5");
    drive(1, 400); drive(0, 10);
    pattern(420, 650, 1150, 10);  expect_pulses(1, "R7");
    drive(1, 400); drive(0, 10); drive(1, 650); drive(0, 10);
    pattern(400, 650, 1150, 10);  expect_pulses(1, "R7");
    drive(1, 2448); drive(0, 10);
    drive(1, 650); drive(0, 10); drive(1, 1150); drive(0, 40);
    expect_pulses(0, "R9");
    pol = 1'b1;
    drive(0, 20);
    pattern(400, 650, 1150, 10);  expect_pulses(1, "R8");
    drive(0, 20);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule